// File: doc/BRIEF.md
# While-Loop Sequencer with Dual-Rail Branch Flag

This block is the control network of a loop that repeats until a Boolean flag goes false. It runs a sequence of stages and never touches data. Each stage asks the external datapath to do one operation through its own request line and waits for that operation's acknowledge. The datapath and its registers sit outside the block.

The first stage reads the input ports. The second stage computes a flag. The third stage reads that flag back. The flag comes in as a dual-rail pair: one rail means true, the other means false, and both low means the value is not ready yet. A true flag runs the body stages in order. A false flag runs the exit stage. Only one of these two branch paths can be active, so their completion signals are merged by an ordinary OR. The merged signal returns control to the input-read stage.

A parameter sets the body to one or two stages. With one stage, the second body slot becomes a pass-through and is never requested. Every other control line is single-rail. The current stage code is brought out so that it can be observed.

Top module: `wloop_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `stage` is 0 (input read), `req` equals 6'b000001 and `flag_err` is low.
- R2: Every stage uses a four-phase handshake. `req[k]`, where k is the code of the current stage, stays high until `ack[k]` is seen high, then goes low. The stage ends, and the next stage's request rises, only after `ack[k]` is seen low again.
- R3: The stage codes are 0 input read, 1 flag compute, 2 flag test, 3 body one, 4 body two and 5 exit. Request bit k belongs to stage k. The stage after 0 is 1, and the stage after 1 is 2.
- R4: At most one bit of `req` is high in any cycle.
- R5: A flag test that sees `flag_t`=1 and `flag_f`=0 is followed by stage 3, then stage 4, then stage 0.
- R6: A flag test that sees `flag_t`=0 and `flag_f`=1 is followed by stage 5, then stage 0.
- R7: When both flag rails are high during the flag test, `flag_err` is high in the next cycle and the sequencer stays in stage 2 with `req[2]` still high.
- R8: While both flag rails are low during the flag test, the sequencer stays in stage 2 with `req[2]` high.
- R9: With `BODY_STAGES`=1, a true flag is followed by stage 3 and then directly by stage 0. Stage 4 is never requested.
- R10: After the flag test has taken a valid flag and dropped `req[2]`, it ends only when both flag rails are low. During the flag test, the flag rails act as the stage's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack | input | 6 | Per-stage acknowledge from the datapath; bit 2 is unused |
| flag_t | input | 1 | True rail of the flag |
| flag_f | input | 1 | False rail of the flag |
| req | output | 6 | Per-stage operation request, one bit per stage code |
| stage | output | 3 | Code of the current stage |
| flag_err | output | 1 | High one cycle after both flag rails are seen high during the flag test |

## Verification
The in-module assertions check on every cycle that at most one request is active and that a null flag holds the test stage. They also check that an illegal flag raises the error, and that each branch decision and each merged completion leads to the correct next stage. Only the bench scenarios can show the complete visit order over several loop passes with a true, true, false flag series. They also show that the handshake waits on the responder's timing, and that the one-stage body variant skips the second body slot.

// File: rtl/wloop_pkg.sv
package wloop_pkg;

    localparam int unsigned NUM_STAGES = 6;
    localparam int unsigned STAGE_W    = $clog2(NUM_STAGES);

    typedef enum logic [STAGE_W-1:0] {
        ST_READ  = 3'd0,
        ST_CALC  = 3'd1,
        ST_TEST  = 3'd2,
        ST_BODY1 = 3'd3,
        ST_BODY2 = 3'd4,
        ST_EXIT  = 3'd5
    } stage_e;

    typedef enum logic {
        PH_ASK  = 1'b0,
        PH_DROP = 1'b1
    } phase_e;

    typedef struct packed {
        stage_e stage;
        phase_e phase;
        logic   flag;
        logic   err;
    } seq_state_t;

endpackage

// File: rtl/wloop_dualrail_rx.sv
module wloop_dualrail_rx (
    input  logic rail_t,
    input  logic rail_f,
    output logic valid,
    output logic any_high,
    output logic illegal,
    output logic value
);
    always_comb begin
        valid    = rail_t ^ rail_f;
        any_high = rail_t | rail_f;
        illegal  = rail_t & rail_f;
        value    = rail_t & ~rail_f;
    end
endmodule

// File: rtl/wloop_hs_phase.sv
module wloop_hs_phase
    import wloop_pkg::*;
(
    input  phase_e phase_q,
    input  logic   rise_ok,
    input  logic   still_busy,
    output phase_e phase_d,
    output logic   capture,
    output logic   done
);
    always_comb begin
        phase_d = phase_q;
        capture = 1'b0;
        done    = 1'b0;
        unique case (phase_q)
            PH_ASK: begin
                if (rise_ok) begin
                    phase_d = PH_DROP;
                    capture = 1'b1;
                end
            end
            PH_DROP: begin
                if (!still_busy) begin
                    phase_d = PH_ASK;
                    done    = 1'b1;
                end
            end
            default: phase_d = PH_ASK;
        endcase
    end
endmodule

// File: rtl/wloop_branch_join.sv
module wloop_branch_join
    import wloop_pkg::*;
#(
    parameter int unsigned BODY_STAGES = 2
) (
    input  stage_e stage_q,
    input  logic   stage_done,
    output logic   join_done
);
    logic body_done;
    logic exit_done;

    generate
        if (BODY_STAGES == 1) begin : g_short_body
            assign body_done = stage_done && (stage_q == ST_BODY1);
        end else begin : g_long_body
            assign body_done = stage_done && (stage_q == ST_BODY2);
        end
    endgenerate

    assign exit_done = stage_done && (stage_q == ST_EXIT);
    assign join_done = body_done | exit_done;
endmodule

// File: rtl/wloop_seq.sv
module wloop_seq
    import wloop_pkg::*;
#(
    parameter int unsigned BODY_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] ack,
    input  logic                  flag_t,
    input  logic                  flag_f,
    output logic [NUM_STAGES-1:0] req,
    output logic [STAGE_W-1:0]    stage,
    output logic                  flag_err
);
    localparam bit SHORT_BODY = (BODY_STAGES == 1);

    seq_state_t cur_q, cur_d;

    logic   fl_valid, fl_any, fl_bad, fl_val;
    logic   ack_sel, rise_ok, still_busy;
    logic   capture, done, join_done;
    phase_e phase_d;
    logic   in_test;

    wloop_dualrail_rx u_rx (
        .rail_t   (flag_t),
        .rail_f   (flag_f),
        .valid    (fl_valid),
        .any_high (fl_any),
        .illegal  (fl_bad),
        .value    (fl_val)
    );

    assign in_test    = (cur_q.stage == ST_TEST);
    assign ack_sel    = ack[cur_q.stage];
    assign rise_ok    = in_test ? fl_valid : ack_sel;
    assign still_busy = in_test ? fl_any   : ack_sel;

    wloop_hs_phase u_hs (
        .phase_q    (cur_q.phase),
        .rise_ok    (rise_ok),
        .still_busy (still_busy),
        .phase_d    (phase_d),
        .capture    (capture),
        .done       (done)
    );

    wloop_branch_join #(.BODY_STAGES(BODY_STAGES)) u_join (
        .stage_q    (cur_q.stage),
        .stage_done (done),
        .join_done  (join_done)
    );

    always_comb begin
        cur_d       = cur_q;
        cur_d.phase = phase_d;
        cur_d.err   = in_test && (cur_q.phase == PH_ASK) && fl_bad;
        if (in_test && capture) begin
            cur_d.flag = fl_val;
        end
        if (join_done) begin
            cur_d.stage = ST_READ;
        end else if (done) begin
            unique case (cur_q.stage)
                ST_READ:  cur_d.stage = ST_CALC;
                ST_CALC:  cur_d.stage = ST_TEST;
                ST_TEST:  cur_d.stage = cur_q.flag ? ST_BODY1 : ST_EXIT;
                ST_BODY1: cur_d.stage = SHORT_BODY ? ST_READ : ST_BODY2;
                default:  cur_d.stage = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{stage: ST_READ, phase: PH_ASK, flag: 1'b0, err: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    always_comb begin
        req = '0;
        for (int k = 0; k < NUM_STAGES; k++) begin
            req[k] = (cur_q.phase == PH_ASK) && (cur_q.stage == stage_e'(k));
        end
    end

    assign stage    = cur_q.stage;
    assign flag_err = cur_q.err;

    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    a_r7_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && cur_q.phase == PH_ASK && flag_t && flag_f)
            |=> (flag_err && stage == ST_TEST && req[ST_TEST]));

    a_r8_null_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && cur_q.phase == PH_ASK && !flag_t && !flag_f)
            |=> (stage == ST_TEST && req[ST_TEST]));

    a_r5_true_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && done && cur_q.flag) |=> (stage == ST_BODY1));

    a_r6_false_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && done && !cur_q.flag) |=> (stage == ST_EXIT));

    a_r6_join_returns: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |=> (stage == ST_READ));

    a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_test && cur_q.phase == PH_ASK && !ack_sel) |=> $stable(req));

endmodule

// File: tb/wloop_seq_tb.sv
module wloop_seq_tb;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_a = 1'b0, rst_b = 1'b0;
    logic [5:0] ack = '0;
    logic       ft = 1'b0, ff = 1'b0;
    logic       which = 1'b0;
    logic [5:0] req_a, req_b, req_v;
    logic [2:0] st_a, st_b, st_v;
    logic       err_a, err_b, err_v;
    int         checks = 0, fails = 0, cyc = 0;
    bit         timed_out = 0;

    // each entry: expected stage code, flag value to give if stage is 2
    localparam logic [3:0] VEC [NV] = '{
        {3'd0,1'b0},{3'd1,1'b0},{3'd2,1'b1},{3'd3,1'b0},{3'd4,1'b0},
        {3'd0,1'b0},{3'd1,1'b0},{3'd2,1'b1},{3'd3,1'b0},{3'd4,1'b0},
        {3'd0,1'b0},{3'd1,1'b0}};

    always #5 clk = ~clk;

    wloop_seq #(.BODY_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_a), .ack(ack), .flag_t(ft), .flag_f(ff),
        .req(req_a), .stage(st_a), .flag_err(err_a));

    wloop_seq #(.BODY_STAGES(1)) u_dut_short (
        .clk(clk), .rst_n(rst_b), .ack(ack), .flag_t(ft), .flag_f(ff),
        .req(req_b), .stage(st_b), .flag_err(err_b));

    assign req_v = which ? req_b : req_a;
    assign st_v  = which ? st_b  : st_a;
    assign err_v = which ? err_b : err_a;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !timed_out) begin
            timed_out = 1;
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<20000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req();
        while (req_v == '0) @(negedge clk);
    endtask

    // visit one stage: check it, then complete its handshake
    task automatic visit(input int exp_st, input logic fv, input string tag);
        wait_req();
        chk({tag, " stage"}, st_v, exp_st);
        chk("R4 onehot req", $countones(req_v), 1);
        chk({tag, " req bit"}, req_v[exp_st], 1);
        if (exp_st == 2) begin
            ft = fv; ff = ~fv;
        end else begin
            ack[exp_st] = 1'b1;
        end
        @(negedge clk);
        chk("R2 req drops after ack", req_v, 0);
        @(negedge clk);
        chk("R2/R10 waits for ack low", req_v, 0);
        ack = '0; ft = 1'b0; ff = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset stage", st_a, 0);
        chk("R1 reset req", req_a, 1);
        chk("R1 reset err", err_a, 0);
        rst_a = 1'b1;
        @(negedge clk);
        chk("R1 stage after reset", st_a, 0);
        chk("R1 req after reset", req_a, 1);

        // R3 R5: two true passes, walk the table
        for (int i = 0; i < NV; i++) begin
            visit(VEC[i][3:1], VEC[i][0], "R3/R5 table");
        end

        // R7 illegal flag, then R8 null hold, then R6 false branch
        wait_req();
        chk("R3 at test", st_a, 2);
        ft = 1'b1; ff = 1'b1;
        @(negedge clk);
        chk("R7 err raised", err_a, 1);
        chk("R7 still test", st_a, 2);
        chk("R7 req held", req_a[2], 1);
        ft = 1'b0; ff = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 null holds stage", st_a, 2);
        chk("R8 null holds req", req_a[2], 1);
        chk("R7 err clears", err_a, 0);
        visit(2, 1'b0, "R6 test false");
        visit(5, 1'b0, "R6 exit");
        visit(0, 1'b0, "R6 back to read");

        // R9 short body variant
        rst_a = 1'b0; which = 1'b1; rst_b = 1'b1;
        @(negedge clk);
        visit(0, 1'b0, "R9 read");
        visit(1, 1'b0, "R9 calc");
        visit(2, 1'b1, "R9 test");
        visit(3, 1'b0, "R9 body");
        wait_req();
        chk("R9 skips body two", st_b, 0);
        chk("R9 body two never requested", req_b[4], 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule